// File: doc/BRIEF.md
# Handshaked Latched Byte Port

This block is one byte-wide parallel port built around a single data register. A mode input chooses the direction. In input mode the register loads from the external side, and the processor bus reads it. In output mode the register loads from the processor bus, and the external side takes it. A strobe input loads the register on its rising edge. Two select inputs, one active low and one active high, gate the output buffer. The three-state output is modelled as a data vector plus an output-enable flag, and the vector reads zero while the flag is off.

An active-low request output gives the handshake. Each load pulls it low. It returns high after the clock in which the buffer was enabled with no load in progress. In input mode the request therefore means "data waiting for the processor". In output mode it means "word loaded, not yet taken", and its rising edge can ask for the next write.

The same block covers three uses. Tying the strobe to the inverted address strobe gives capture on every bus cycle. A strobe from external logic gives a handshaked input. A strobe built from address decode and output data strobe gives an output port, and holding both selects active passes each new word straight through. Two ports that share every control signal form a sixteen-bit port.

Top module: `hs_port`

## Requirements
- R1: A synchronous active-high reset clears the register to zero and sets the request output `req_n` high.
- R2: The register loads only on a rising edge of `stb`, meaning `stb` is high in a clock cycle and was low in the one before. Keeping `stb` high causes no further loads, so input changes while it stays high are ignored.
- R3: The output buffer is enabled only when `sel_n` is 0 and `sel` is 1. While it is disabled, both enable flags are 0 and both data outputs read zero.
- R4: From the clock edge that performs a load, `req_n` reads 0.
- R5: When the buffer is enabled on a clock edge that performs no load, `req_n` reads 1 from that edge on.
- R6: A load while a request is pending replaces the register contents with the new word, and `req_n` stays 0.
- R7: While the buffer is held enabled, each loaded word appears on the active data output right after its load edge. `req_n` is then low for exactly one clock.
- R8: `mode` = 0 selects input: the register loads from `ext_din` and drives `bus_dout`/`bus_oe`. `mode` = 1 selects output: the register loads from `bus_din` and drives `ext_dout`/`ext_oe`. The inactive side's enable flag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = input port, 1 = output port |
| sel_n | input | 1 | Active-low buffer select |
| sel | input | 1 | Active-high buffer select |
| stb | input | 1 | Load strobe, rising edge loads |
| bus_din | input | W | Processor-side data into the register (output mode) |
| bus_dout | output | W | Processor-side data out (input mode), zero when disabled |
| bus_oe | output | 1 | Processor-side drive enable |
| ext_din | input | W | External data into the register (input mode) |
| ext_dout | output | W | External data out (output mode), zero when disabled |
| ext_oe | output | 1 | External-side drive enable |
| req_n | output | 1 | Active-low service request |

## Verification
The bench sends every byte value through both directions on a sixteen-bit pair of ports, with each half carrying a different byte. A swapped data source or a swapped output side would therefore show up at once. It holds the strobe high while changing the input. A level-sensitive load would overwrite the word, and a repeated edge would keep the request stuck. It loads twice without a read, to catch a design that cleared the request or kept the stale word. It also holds both selects active, where a design that gave the read priority over a load would lose the request pulse or show the new word a clock late.

// File: rtl/hs_port_pkg.sv
`timescale 1ns/1ps
package hs_port_pkg;

    localparam int PORT_W = 8;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } dir_e;

    // Buffer enable: low-active select low and high-active select high.
    function automatic logic buf_enable(input logic sel_lo, input logic sel_hi);
        return !sel_lo && sel_hi;
    endfunction

endpackage

// File: rtl/hs_port_strobe.sv
`timescale 1ns/1ps
module hs_port_strobe (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic load
);
    logic stb_q;

    always_ff @(posedge clk) begin
        if (rst) stb_q <= 1'b0;
        else     stb_q <= stb;
    end

    assign load = stb && !stb_q;

    // R2: a load never occurs two cycles in a row
    p_single_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);
endmodule

// File: rtl/hs_port_latch.sv
`timescale 1ns/1ps
module hs_port_latch
    import hs_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_e         dir,
    input  logic         load,
    input  logic [W-1:0] from_bus,
    input  logic [W-1:0] from_ext,
    output logic [W-1:0] q
);
    logic [W-1:0] src;

    always_comb begin
        unique case (dir)
            DIR_IN:  src = from_ext;
            DIR_OUT: src = from_bus;
            default: src = from_ext;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= src;
    end

    // R2/R8: after a load the register holds the chosen source
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> q == $past(src));
    // R2: without a load the register keeps its value
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/hs_port_req.sv
`timescale 1ns/1ps
module hs_port_req (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic taken,
    output logic req_n
);
    always_ff @(posedge clk) begin
        if (rst)        req_n <= 1'b1;
        else if (load)  req_n <= 1'b0;   // load wins over a read in the same cycle
        else if (taken) req_n <= 1'b1;
    end

    // R1: reset releases the request
    p_reset_r1: assert property (@(posedge clk) rst |=> req_n);
    // R4: a load raises the request
    p_req_set_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> !req_n);
    // R5: an enabled cycle with no load drops the request
    p_req_clr_r5: assert property (@(posedge clk) disable iff (rst)
        (taken && !load) |=> req_n);
    // R6: a load over a pending request keeps it pending
    p_hold_pending_r6: assert property (@(posedge clk) disable iff (rst)
        (load && !req_n) |=> !req_n);
endmodule

// File: rtl/hs_port.sv
`timescale 1ns/1ps
module hs_port
    import hs_port_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mode,
    input  logic         sel_n,
    input  logic         sel,
    input  logic         stb,
    input  logic [W-1:0] bus_din,
    output logic [W-1:0] bus_dout,
    output logic         bus_oe,
    input  logic [W-1:0] ext_din,
    output logic [W-1:0] ext_dout,
    output logic         ext_oe,
    output logic         req_n
);
    dir_e         dir;
    logic         load;
    logic         en;
    logic [W-1:0] q;

    assign dir = dir_e'(mode);
    assign en  = buf_enable(sel_n, sel);

    hs_port_strobe u_strobe (
        .clk  (clk),
        .rst  (rst),
        .stb  (stb),
        .load (load)
    );

    hs_port_latch #(.W(W)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .dir      (dir),
        .load     (load),
        .from_bus (bus_din),
        .from_ext (ext_din),
        .q        (q)
    );

    hs_port_req u_req (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .taken (en),
        .req_n (req_n)
    );

    always_comb begin
        bus_oe   = en && (dir == DIR_IN);
        ext_oe   = en && (dir == DIR_OUT);
        bus_dout = bus_oe ? q : '0;
        ext_dout = ext_oe ? q : '0;
    end

    // R8: the processor side never drives in output mode
    p_dir_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == 1'b1) |-> !bus_oe);
    // R3: a disabled port shows zero on both data outputs
    p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (sel_n || !sel) |-> (bus_dout == '0 && ext_dout == '0));
endmodule

// File: tb/test_hs_port.sv
`timescale 1ns/1ps
module test_hs_port;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b0, sel_n = 1'b1, sel = 1'b0, stb = 1'b0;
    logic [15:0] bus_din = '0, ext_din = '0;
    logic [15:0] bus_dout, ext_dout;
    logic bus_oe_lo, bus_oe_hi, ext_oe_lo, ext_oe_hi, req_lo, req_hi;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hs_port #(.W(8)) i_hs_port (
        .clk(clk), .rst(rst), .mode(mode), .sel_n(sel_n), .sel(sel), .stb(stb),
        .bus_din(bus_din[7:0]), .bus_dout(bus_dout[7:0]), .bus_oe(bus_oe_lo),
        .ext_din(ext_din[7:0]), .ext_dout(ext_dout[7:0]), .ext_oe(ext_oe_lo),
        .req_n(req_lo)
    );

    hs_port #(.W(8)) i_hs_port_hi (
        .clk(clk), .rst(rst), .mode(mode), .sel_n(sel_n), .sel(sel), .stb(stb),
        .bus_din(bus_din[15:8]), .bus_dout(bus_dout[15:8]), .bus_oe(bus_oe_hi),
        .ext_din(ext_din[15:8]), .ext_dout(ext_dout[15:8]), .ext_oe(ext_oe_hi),
        .req_n(req_hi)
    );

    task automatic chk(input string r, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // rising strobe for one clock, then low for one clock
    task automatic pulse();
        stb = 1'b1;
        @(negedge clk);
        stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic select(input logic on);
        sel_n = !on;
        sel   = on;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req after reset", {req_hi, req_lo}, 16'h0003);
        rst = 1'b0;
        select(1'b1);
        #1 chk("R1 cleared register", bus_dout, 16'h0000);
        @(negedge clk);
        select(1'b0);

        // R8/R2/R4/R5: input mode sweep, ext -> bus
        mode = 1'b0;
        for (int v = 0; v < 256; v++) begin
            ext_din = {8'(255 - v), 8'(v)};
            pulse();
            chk("R4 request after input load", {req_hi, req_lo}, 16'h0000);
            chk("R3 no drive unselected", {bus_oe_hi, bus_oe_lo, bus_dout[7:0]}, 16'h0000);
            select(1'b1);
            #1;
            chk("R8 input data on bus", bus_dout, {8'(255 - v), 8'(v)});
            chk("R8 ext side idle in input mode", {ext_oe_hi, ext_oe_lo, ext_dout[7:0]}, 16'h0000);
            @(negedge clk);
            select(1'b0);
            chk("R5 request cleared by read", {req_hi, req_lo}, 16'h0003);
        end

        // R8: output mode sweep, bus -> ext
        mode = 1'b1;
        for (int v = 0; v < 256; v++) begin
            bus_din = {8'(v ^ 8'h5a), 8'(v)};
            pulse();
            chk("R4 request after output load", {req_hi, req_lo}, 16'h0000);
            select(1'b1);
            #1;
            chk("R8 output data on ext", ext_dout, {8'(v ^ 8'h5a), 8'(v)});
            chk("R8 bus side idle in output mode", {bus_oe_hi, bus_oe_lo, bus_dout[7:0]}, 16'h0000);
            @(negedge clk);
            select(1'b0);
            chk("R5 request cleared by external read", {req_hi, req_lo}, 16'h0003);
        end

        // R3: every select combination in both modes
        for (int m = 0; m < 2; m++) begin
            mode = m[0];
            for (int c = 0; c < 4; c++) begin
                sel_n = c[1];
                sel   = c[0];
                #1;
                chk("R3 bus enable gating", {15'b0, bus_oe_lo}, {15'b0, (c == 1) && (m == 0)});
                chk("R3 ext enable gating", {15'b0, ext_oe_lo}, {15'b0, (c == 1) && (m == 1)});
                @(negedge clk);
            end
        end
        select(1'b0);

        // R2: strobe held high, input changes ignored
        mode = 1'b0;
        ext_din = 16'h1111;
        stb = 1'b1;
        @(negedge clk);
        ext_din = 16'h2222;
        @(negedge clk);
        chk("R4 request while strobe high", {15'b0, req_lo}, 16'h0000);
        select(1'b1);
        #1 chk("R2 held strobe loads once", bus_dout, 16'h1111);
        @(negedge clk);
        select(1'b0);
        @(negedge clk);
        chk("R2 no reload while strobe stays high", {15'b0, req_lo}, 16'h0001);
        stb = 1'b0;
        @(negedge clk);

        // R6: overwrite while pending
        ext_din = 16'h3333;
        pulse();
        ext_din = 16'h4444;
        pulse();
        chk("R6 request still pending", {req_hi, req_lo}, 16'h0000);
        select(1'b1);
        #1 chk("R6 newest word kept", bus_dout, 16'h4444);
        @(negedge clk);
        select(1'b0);
        chk("R5 cleared after overwrite read", {req_hi, req_lo}, 16'h0003);

        // R7: continuous enable in output mode
        mode = 1'b1;
        select(1'b1);
        @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            bus_din = 16'(k * 16'h1357 + 16'h0101);
            stb = 1'b1;
            @(negedge clk);
            chk("R7 word passes through at once", ext_dout, 16'(k * 16'h1357 + 16'h0101));
            chk("R7 request low after load", {15'b0, req_lo}, 16'h0000);
            stb = 1'b0;
            @(negedge clk);
            chk("R7 request low for one clock", {15'b0, req_lo}, 16'h0001);
        end
        select(1'b0);

        // R1: reset mid-operation
        mode = 1'b0;
        ext_din = 16'habcd;
        pulse();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears request", {req_hi, req_lo}, 16'h0003);
        select(1'b1);
        #1 chk("R1 reset clears register", bus_dout, 16'h0000);
        @(negedge clk);
        select(1'b0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule